// File: doc/BRIEF.md
# Indexed Display Mode Register File

This block holds the mode settings of a simple linear-framebuffer display controller and serves them to a host over a plain strobe bus. The host reaches two banks. The first is the mode bank. Its 16-bit registers are selected by an index, which is the byte address with its lowest bit dropped. The second is a small 32-bit extension bank. It reports its own size and holds the framebuffer byte-order flag.

The stored settings drive the pixel pipeline continuously through dedicated outputs: visible width and height, bits per pixel, enable, virtual line width, and the X and Y panning offsets, plus the byte-order flag. Two mode-bank reads are not backed by storage. The identity index returns a fixed version code. The memory index returns the size of video memory counted in 64 KiB units. Indices past the implemented set read as all ones and drop writes. Every read answers exactly one cycle after its strobe, with a one-cycle valid pulse.

Top module: `disp_regs`

## Requirements
- R1: After reset every mode register, every display output and the byte-order flag are zero. This means the display is disabled and the framebuffer is little-endian.
- R2: A mode-bank write (`req_ext`=0) stores `req_wdata[15:0]` at index `req_addr>>1`, so `req_addr[0]` is ignored. A read returns the data on `rsp_data` in the cycle after the `req_rd` strobe, with `rsp_valid` high for that one cycle only.
- R3: A mode-bank read of index 0 returns the identity code 16'hB0C5, whatever was written there.
- R4: A mode-bank read of index 10 returns the video memory size divided by 65536 (256 by default). Writes to index 10 are dropped.
- R5: A mode-bank read at index 11 or above returns 32'h0000FFFF. A write at index 10 or above changes no register and no output.
- R6: Indices 1, 2, 3, 4, 6, 8 and 9 drive `disp_width`, `disp_height`, `disp_bpp`, `disp_enable`, `disp_virt_width`, `disp_x_off` and `disp_y_off`, in that order. The new value is visible on the cycle after the write.
- R7: An extension-bank word read at byte offset 0 returns the bank size, 8. A word read at any offset other than 0 or 4 returns zero.
- R8: A word write at extension offset 4 sets `fb_big_endian` for 32'hBEBEBEBE and clears it for 32'h1E1E1E1E. Any other value leaves it unchanged. A word read at offset 4 returns whichever of those two codes matches the flag.
- R9: Extension accesses with `req_word`=0 are ignored: writes change nothing and reads return zero.
- R10: Mode-bank read data is zero-extended, so bits 31:16 of `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_ext | input | 1 | 1 selects the extension bank, 0 the mode bank |
| req_word | input | 1 | 1 when the access is a full 32-bit word |
| req_addr | input | ADDR_W | Byte address within the selected bank |
| req_wdata | input | 32 | Write data |
| rsp_data | output | 32 | Registered read data |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| disp_width | output | 16 | Visible width |
| disp_height | output | 16 | Visible height |
| disp_bpp | output | 16 | Bits per pixel |
| disp_enable | output | 16 | Enable register |
| disp_virt_width | output | 16 | Virtual line width |
| disp_x_off | output | 16 | Horizontal panning offset |
| disp_y_off | output | 16 | Vertical panning offset |
| fb_big_endian | output | 1 | Framebuffer byte-order flag |

## Verification
The assertions take for granted that the host never raises `req_rd` and `req_wr` in the same cycle. One property checks this as an input rule. The bench keeps within that rule by issuing every access from a task that raises one strobe for one cycle and drops it before the next access. The properties on out-of-range writes and on ignored byte-order values assume that outputs move only because of writes. The bench therefore drives no write alongside the stimulus those properties watch.

// File: rtl/disp_regs.sv
module disp_regs #(
  parameter int          ADDR_W        = 8,
  parameter int          NUM_REGS      = 10,
  parameter int          MEM_IDX       = 10,
  parameter int          VRAM_BYTES    = 16 * 1024 * 1024,
  parameter logic [15:0] ID_VALUE      = 16'hB0C5,
  parameter int          EXT_BYTES     = 8,
  parameter int          EXT_SIZE_OFF  = 0,
  parameter int          EXT_ORDER_OFF = 4,
  parameter logic [31:0] BIG_CODE      = 32'hBEBE_BEBE,
  parameter logic [31:0] LITTLE_CODE   = 32'h1E1E_1E1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_ext,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_data,
  output logic              rsp_valid,
  output logic [15:0]       disp_width,
  output logic [15:0]       disp_height,
  output logic [15:0]       disp_bpp,
  output logic [15:0]       disp_enable,
  output logic [15:0]       disp_virt_width,
  output logic [15:0]       disp_x_off,
  output logic [15:0]       disp_y_off,
  output logic              fb_big_endian
);
  localparam int          IDX_W     = ADDR_W - 1;
  localparam logic [15:0] MEM_UNITS = 16'(VRAM_BYTES / 65536);
  localparam int IX_ID = 0, IX_XRES = 1, IX_YRES = 2, IX_BPP = 3, IX_EN = 4;
  localparam int IX_VW = 6, IX_XOFF = 8, IX_YOFF = 9;

  logic [15:0]      regs [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic             mode_wr, ext_word_wr;
  logic [15:0]      mode_rd_val;
  logic [31:0]      ext_rd_val;

  assign idx         = req_addr[ADDR_W-1:1];
  assign mode_wr     = req_wr && !req_ext;
  assign ext_word_wr = req_wr && req_ext && req_word;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (mode_wr && idx == IDX_W'(i))
        regs[i] <= req_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fb_big_endian <= 1'b0;
    else if (ext_word_wr && req_addr == ADDR_W'(EXT_ORDER_OFF)) begin
      if (req_wdata == BIG_CODE)    fb_big_endian <= 1'b1;
      if (req_wdata == LITTLE_CODE) fb_big_endian <= 1'b0;
    end
  end

  always_comb begin
    mode_rd_val = 16'hFFFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) mode_rd_val = regs[i];
    if (idx == IDX_W'(IX_ID))   mode_rd_val = ID_VALUE;
    if (idx == IDX_W'(MEM_IDX)) mode_rd_val = MEM_UNITS;
  end

  always_comb begin
    ext_rd_val = '0;
    if (req_word) begin
      if (req_addr == ADDR_W'(EXT_SIZE_OFF))  ext_rd_val = 32'(EXT_BYTES);
      if (req_addr == ADDR_W'(EXT_ORDER_OFF)) ext_rd_val = fb_big_endian ? BIG_CODE : LITTLE_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_rd;
      if (req_rd) rsp_data <= req_ext ? ext_rd_val : {16'h0000, mode_rd_val};
    end
  end

  assign disp_width      = regs[IX_XRES];
  assign disp_height     = regs[IX_YRES];
  assign disp_bpp        = regs[IX_BPP];
  assign disp_enable     = regs[IX_EN];
  assign disp_virt_width = regs[IX_VW];
  assign disp_x_off      = regs[IX_XOFF];
  assign disp_y_off      = regs[IX_YOFF];
endmodule

// File: rtl/disp_regs_chk.sv
module disp_regs_chk #(
  parameter int          ADDR_W        = 8,
  parameter int          NUM_REGS      = 10,
  parameter logic [15:0] ID_VALUE      = 16'hB0C5,
  parameter int          EXT_ORDER_OFF = 4,
  parameter logic [31:0] BIG_CODE      = 32'hBEBE_BEBE,
  parameter logic [31:0] LITTLE_CODE   = 32'h1E1E_1E1E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_wr,
  input logic              req_ext,
  input logic              req_word,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_data,
  input logic              rsp_valid,
  input logic [15:0]       disp_width,
  input logic [15:0]       disp_height,
  input logic [15:0]       disp_bpp,
  input logic [15:0]       disp_enable,
  input logic [15:0]       disp_virt_width,
  input logic [15:0]       disp_x_off,
  input logic [15:0]       disp_y_off,
  input logic              fb_big_endian
);
  localparam int IDX_W = ADDR_W - 1;
  logic [IDX_W-1:0] idx;
  logic [111:0]     outs;
  logic             order_wr;
  assign idx      = req_addr[ADDR_W-1:1];
  assign outs     = {disp_width, disp_height, disp_bpp, disp_enable,
                     disp_virt_width, disp_x_off, disp_y_off};
  assign order_wr = req_wr && req_ext && req_word && req_addr == ADDR_W'(EXT_ORDER_OFF);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && req_wr));
  p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid);
  p_id_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_ext && idx == '0) |=> rsp_data == {16'h0000, ID_VALUE});
  p_oob_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_ext && idx > IDX_W'(NUM_REGS)) |=> rsp_data == 32'h0000_FFFF);
  p_oob_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !req_ext && idx >= IDX_W'(NUM_REGS)) |=> $stable(outs));
  p_big_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (order_wr && req_wdata == BIG_CODE) |=> fb_big_endian);
  p_little_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (order_wr && req_wdata == LITTLE_CODE) |=> !fb_big_endian);
  p_other_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (order_wr && req_wdata != BIG_CODE && req_wdata != LITTLE_CODE) |=> $stable(fb_big_endian));
  p_narrow_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_ext && !req_word) |=> $stable(fb_big_endian));
  p_mode_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !req_ext) |=> rsp_data[31:16] == 16'h0000);
endmodule

bind disp_regs disp_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE),
  .EXT_ORDER_OFF(EXT_ORDER_OFF), .BIG_CODE(BIG_CODE), .LITTLE_CODE(LITTLE_CODE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_ext(req_ext),
  .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_data(rsp_data), .rsp_valid(rsp_valid), .disp_width(disp_width),
  .disp_height(disp_height), .disp_bpp(disp_bpp), .disp_enable(disp_enable),
  .disp_virt_width(disp_virt_width), .disp_x_off(disp_x_off),
  .disp_y_off(disp_y_off), .fb_big_endian(fb_big_endian)
);

// File: tb/test_disp_regs.sv
module test_disp_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rd = 1'b0, req_wr = 1'b0, req_ext = 1'b0, req_word = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_data;
  logic        rsp_valid;
  logic [15:0] disp_width, disp_height, disp_bpp, disp_enable;
  logic [15:0] disp_virt_width, disp_x_off, disp_y_off;
  logic        fb_big_endian;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_regs i_disp_regs (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_ext(req_ext),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .disp_width(disp_width),
    .disp_height(disp_height), .disp_bpp(disp_bpp), .disp_enable(disp_enable),
    .disp_virt_width(disp_virt_width), .disp_x_off(disp_x_off),
    .disp_y_off(disp_y_off), .fb_big_endian(fb_big_endian)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit ext, bit word, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_ext = ext; req_word = word; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  task automatic rd_check(string req, bit ext, bit word, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    req_rd = 1'b1; req_ext = ext; req_word = word; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    check({req, " data"}, rsp_data, exp);
    check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    @(negedge clk);
    check({req, " valid drop"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 outputs", {disp_width, disp_height}, 32'd0);
    check("R1 outputs2", {disp_bpp, disp_enable}, 32'd0);
    check("R1 outputs3", {disp_virt_width, disp_x_off}, 32'd0);
    check("R1 yoff", {16'd0, disp_y_off}, 32'd0);
    check("R1 order", {31'd0, fb_big_endian}, 32'd0);
    check("R1 valid", {31'd0, rsp_valid}, 32'd0);
    rd_check("R1 width read", 1'b0, 1'b0, 8'd2, 32'd0);
  endtask

  task automatic t_store();
    wr(1'b0, 1'b0, 8'd2, 32'hAAAA_0280);
    wr(1'b0, 1'b0, 8'd4, 32'd480);
    wr(1'b0, 1'b0, 8'd6, 32'd32);
    wr(1'b0, 1'b0, 8'd8, 32'd1);
    wr(1'b0, 1'b0, 8'd12, 32'd800);
    wr(1'b0, 1'b0, 8'd16, 32'd5);
    wr(1'b0, 1'b0, 8'd18, 32'd7);
    @(negedge clk);
    check("R6 width", {16'd0, disp_width}, 32'd640);
    check("R6 height", {16'd0, disp_height}, 32'd480);
    check("R6 bpp", {16'd0, disp_bpp}, 32'd32);
    check("R6 enable", {16'd0, disp_enable}, 32'd1);
    check("R6 virt width", {16'd0, disp_virt_width}, 32'd800);
    check("R6 offsets", {disp_x_off, disp_y_off}, {16'd5, 16'd7});
    rd_check("R2 R10 readback", 1'b0, 1'b0, 8'd2, 32'd640);
    wr(1'b0, 1'b0, 8'd3, 32'd1024);
    @(negedge clk);
    check("R2 odd address", {16'd0, disp_width}, 32'd1024);
    wr(1'b0, 1'b0, 8'd14, 32'd600);
    rd_check("R2 unmapped stored", 1'b0, 1'b1, 8'd14, 32'd600);
  endtask

  task automatic t_fixed();
    wr(1'b0, 1'b0, 8'd0, 32'h1234);
    rd_check("R3 identity", 1'b0, 1'b0, 8'd0, 32'h0000_B0C5);
    rd_check("R4 memory size", 1'b0, 1'b0, 8'd20, 32'd256);
    wr(1'b0, 1'b0, 8'd20, 32'h55);
    rd_check("R4 memory after write", 1'b0, 1'b0, 8'd20, 32'd256);
  endtask

  task automatic t_oob();
    wr(1'b0, 1'b0, 8'd30, 32'h0000_4444);
    wr(1'b0, 1'b0, 8'd21, 32'h0000_3333);
    @(negedge clk);
    check("R5 write dropped", {disp_width, disp_height}, {16'd1024, 16'd480});
    check("R5 write dropped2", {disp_x_off, disp_y_off}, {16'd5, 16'd7});
    rd_check("R5 read idx15", 1'b0, 1'b0, 8'd30, 32'h0000_FFFF);
    rd_check("R5 read idx11", 1'b0, 1'b0, 8'd22, 32'h0000_FFFF);
  endtask

  task automatic t_ext();
    rd_check("R7 size", 1'b1, 1'b1, 8'd0, 32'd8);
    rd_check("R7 other zero", 1'b1, 1'b1, 8'd8, 32'd0);
    rd_check("R8 little code", 1'b1, 1'b1, 8'd4, 32'h1E1E_1E1E);
    wr(1'b1, 1'b1, 8'd4, 32'hBEBE_BEBE);
    check("R8 set", {31'd0, fb_big_endian}, 32'd1);
    rd_check("R8 big code", 1'b1, 1'b1, 8'd4, 32'hBEBE_BEBE);
    wr(1'b1, 1'b1, 8'd4, 32'h1234_5678);
    check("R8 other keeps", {31'd0, fb_big_endian}, 32'd1);
    wr(1'b1, 1'b1, 8'd4, 32'h1E1E_1E1E);
    check("R8 clear", {31'd0, fb_big_endian}, 32'd0);
    wr(1'b1, 1'b0, 8'd4, 32'hBEBE_BEBE);
    check("R9 narrow write", {31'd0, fb_big_endian}, 32'd0);
    rd_check("R9 narrow read", 1'b1, 1'b0, 8'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store();
    t_fixed();
    t_oob();
    t_ext();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule